// File: doc/BRIEF.md
# Banked GPIO Controller with Edge Capture

This block lets a processor drive and observe a set of general-purpose pins. The pins are grouped in banks of 32. Each bank has a window of ten 32-bit registers on a word-addressed register bus that uses plain read and write strobes. Through this window software does four things. It picks each pin's direction. It changes output levels with atomic set and clear writes, so it never needs a read-modify-write. It reads a synchronized copy of every pad level. It arms rising-edge and falling-edge capture separately for each pin.

Each incoming pad level passes through two flops before anything uses it. A captured edge stays in a per-bank status word until software writes a one to that bit. One interrupt line stays high while any status bit in any bank is set. With the default of 71 pins there are three banks, and only the low seven bits of the last bank exist.

Top module: `gpio_edge_ctrl`

## Requirements
- R1: After reset every pin is an input, so `pad_oe` is all zeros. `pad_out` is all zeros. All edge enables and status bits are zero, and `irq` is low.
- R2: Bank b occupies word addresses 4+10b to 13+10b, which are byte offsets 0x10, 0x38 and 0x60. Within a bank, word k holds: 0 direction, 1 output data, 2 set output, 3 clear output, 4 input level, 5 set rising enable, 6 clear rising enable, 7 set falling enable, 8 clear falling enable, 9 status. Pin n is bit n%32 of bank n/32. `bus_rdata` is combinational and reads zero while `bus_rd` is low.
- R3: In the direction word a 1 means input and a 0 means output. The word can be read and written, and `pad_oe` for each pin is the inverse of its direction bit.
- R4: A write to word 1 loads the output data. A write to word 2 forces to 1 every output bit whose data bit is 1. A write to word 3 forces those bits to 0. Zero data bits leave outputs unchanged. Words 1, 2 and 3 all read back the current output data.
- R5: Word 4 returns the synchronized pad level whatever the pin's direction. A pad level that is present before clock edge E becomes readable after edge E+1.
- R6: Words 5 and 6 set and clear bits of the rising-edge enable mask, and words 7 and 8 do the same for the falling-edge mask. Each word reads back the mask it modifies.
- R7: An edge is a change between two consecutive synchronized samples. When the matching enable is set, a pad change present before edge E sets the status bit at edge E+2. No disabled edge ever sets a bit.
- R8: Status bits stay set until a 1 is written to them in word 9. Writing a 0 has no effect. An edge captured in the same cycle as the clearing write leaves its bit set.
- R9: `irq` is high exactly when at least one status bit in any bank is set.
- R10: Word addresses below 4 or beyond the last bank read zero, and writes to them are ignored. Writes to word 4 are ignored. Bits for pins that do not exist in the last bank read zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for registers and pad sampling |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, gates `bus_rdata` |
| bus_addr | input | ADDR_W (6) | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| pad_in | input | NUM_PINS (71) | Raw pad levels, asynchronous |
| pad_out | output | NUM_PINS (71) | Output data driven to the pads |
| pad_oe | output | NUM_PINS (71) | Pad output enables, 1 drives the pad |
| irq | output | 1 | Combined edge interrupt |

## Verification
The assertions assume that a write strobe lasts one cycle and carries a stable address and data. They also assume that `bus_rd` and `bus_wr` never address unmapped words with intent to change state. The stickiness check assumes that nothing but a bus write can drop a status bit. The stimulus keeps to these rules because every access goes through a single write or read task. Random pad changes are only applied between bus accesses and are followed by a settling gap, so the reference model sees each edge one at a time. One directed case puts a clearing write on the exact cycle an edge lands.

// File: rtl/gpio_edge_pkg.sv
// Shared constants and the register index type of the banked GPIO controller.
// Assumes a word-addressed bus; the bank layout is fixed by the indices below.
package gpio_edge_pkg;

    localparam int BANK_W        = 32;  // pins per bank and data word width
    localparam int REGS_PER_BANK = 10;  // words in each bank window
    localparam int BASE_WORD     = 4;   // word address of the first bank (byte 0x10)

    // Word index inside a bank window; the order is part of the memory map.
    typedef enum logic [3:0] {
        REG_DIR      = 4'd0,
        REG_OUT      = 4'd1,
        REG_SET      = 4'd2,
        REG_CLR      = 4'd3,
        REG_IN       = 4'd4,
        REG_RISE_SET = 4'd5,
        REG_RISE_CLR = 4'd6,
        REG_FALL_SET = 4'd7,
        REG_FALL_CLR = 4'd8,
        REG_STAT     = 4'd9
    } reg_idx_e;

endpackage

// File: rtl/gpio_sync2.sv
// Two-flop synchronizer for a vector of asynchronous pad levels.
// Assumes each bit is an independent level; no multi-bit coherence is implied.
module gpio_sync2 #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw,
    output logic [W-1:0] level
);

    logic [W-1:0] stage1;

    // Shift the raw levels through two flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= '0;
            level  <= '0;
        end else begin
            stage1 <= raw;
            level  <= stage1;
        end
    end

endmodule

// File: rtl/gpio_edge_det.sv
// Per-pin edge detector working on already synchronized levels.
// An edge is a difference between the current and the previous sample,
// filtered by separate rising and falling enable masks.
module gpio_edge_det #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] level,
    input  logic [W-1:0] rise_en,
    input  logic [W-1:0] fall_en,
    output logic [W-1:0] hit
);

    logic [W-1:0] prev;

    // Remember the previous synchronized sample.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= '0;
        else        prev <= level;
    end

    // Flag enabled transitions between the two samples.
    always_comb begin
        hit = (level & ~prev & rise_en) | (~level & prev & fall_en);
    end

endmodule

// File: rtl/gpio_bank.sv
// One bank of up to 32 pins: direction, output data with atomic set/clear,
// synchronized input, edge enables and sticky write-one-to-clear status.
// Assumes the parent decodes the address: sel is high only for this window
// and idx is then 0..9. W is the number of pins that exist in this bank.
module gpio_bank
    import gpio_edge_pkg::*;
#(
    parameter int W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              wr,
    input  logic [3:0]        idx,
    input  logic [W-1:0]      wdata,
    input  logic [W-1:0]      pad_raw,
    output logic [BANK_W-1:0] rdata,
    output logic [W-1:0]      out_q,
    output logic [W-1:0]      oe,
    output logic              any_stat
);

    logic [W-1:0] dir_q;
    logic [W-1:0] rise_q;
    logic [W-1:0] fall_q;
    logic [W-1:0] stat_q;
    logic [W-1:0] level;
    logic [W-1:0] hit;
    logic [W-1:0] stat_clr;
    logic         wr_here;

    assign wr_here = sel && wr;

    gpio_sync2 #(.W(W)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .raw   (pad_raw),
        .level (level)
    );

    gpio_edge_det #(.W(W)) u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .level   (level),
        .rise_en (rise_q),
        .fall_en (fall_q),
        .hit     (hit)
    );

    // Control registers updated by bus writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q  <= '1;
            out_q  <= '0;
            rise_q <= '0;
            fall_q <= '0;
        end else if (wr_here) begin
            case (idx)
                REG_DIR:      dir_q  <= wdata;
                REG_OUT:      out_q  <= wdata;
                REG_SET:      out_q  <= out_q | wdata;
                REG_CLR:      out_q  <= out_q & ~wdata;
                REG_RISE_SET: rise_q <= rise_q | wdata;
                REG_RISE_CLR: rise_q <= rise_q & ~wdata;
                REG_FALL_SET: fall_q <= fall_q | wdata;
                REG_FALL_CLR: fall_q <= fall_q & ~wdata;
                default:      ;
            endcase
        end
    end

    // Bits that the current write asks to clear in the status word.
    always_comb begin
        stat_clr = (wr_here && idx == REG_STAT) ? wdata : '0;
    end

    // Sticky status: a new hit wins over a simultaneous clear.
    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= (stat_q & ~stat_clr) | hit;
    end

    // Read multiplexer for this bank, zero when not selected.
    always_comb begin
        rdata = '0;
        if (sel) begin
            case (idx)
                REG_DIR:                        rdata = BANK_W'(dir_q);
                REG_OUT, REG_SET, REG_CLR:      rdata = BANK_W'(out_q);
                REG_IN:                         rdata = BANK_W'(level);
                REG_RISE_SET, REG_RISE_CLR:     rdata = BANK_W'(rise_q);
                REG_FALL_SET, REG_FALL_CLR:     rdata = BANK_W'(fall_q);
                REG_STAT:                       rdata = BANK_W'(stat_q);
                default:                        rdata = '0;
            endcase
        end
    end

    assign oe       = ~dir_q;
    assign any_stat = |stat_q;

endmodule

// File: rtl/gpio_edge_ctrl.sv
// Banked GPIO controller top. It decodes word addresses into bank windows,
// merges read data and status, and slices the pad vectors per bank.
// Assumes NUM_PINS fits in ADDR_W: BASE_WORD + banks*10 <= 2**ADDR_W.
module gpio_edge_ctrl
    import gpio_edge_pkg::*;
#(
    parameter int NUM_PINS = 71,
    parameter int ADDR_W   = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_wr,
    input  logic                bus_rd,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [BANK_W-1:0]   bus_wdata,
    output logic [BANK_W-1:0]   bus_rdata,
    input  logic [NUM_PINS-1:0] pad_in,
    output logic [NUM_PINS-1:0] pad_out,
    output logic [NUM_PINS-1:0] pad_oe,
    output logic                irq
);

    localparam int NUM_BANKS = (NUM_PINS + BANK_W - 1) / BANK_W;

    logic [BANK_W-1:0] bank_rdata [NUM_BANKS];
    logic [NUM_BANKS-1:0] bank_stat;
    logic [BANK_W-1:0] rd_merge;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        localparam int LO  = b * BANK_W;
        localparam int W   = (NUM_PINS - LO >= BANK_W) ? BANK_W : NUM_PINS - LO;
        localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(BASE_WORD + b * REGS_PER_BANK);
        localparam logic [ADDR_W-1:0] END_A  = ADDR_W'(BASE_WORD + (b + 1) * REGS_PER_BANK);

        logic              sel;
        logic [ADDR_W-1:0] off;

        // Window decode for this bank.
        always_comb begin
            sel = (bus_addr >= BASE_A) && (bus_addr < END_A);
            off = bus_addr - BASE_A;
        end

        gpio_bank #(.W(W)) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .sel      (sel),
            .wr       (bus_wr),
            .idx      (off[3:0]),
            .wdata    (bus_wdata[W-1:0]),
            .pad_raw  (pad_in[LO +: W]),
            .rdata    (bank_rdata[b]),
            .out_q    (pad_out[LO +: W]),
            .oe       (pad_oe[LO +: W]),
            .any_stat (bank_stat[b])
        );
    end

    // Merge the per-bank read data; at most one bank is selected.
    always_comb begin
        rd_merge = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            rd_merge = rd_merge | bank_rdata[b];
        end
    end

    assign bus_rdata = bus_rd ? rd_merge : '0;
    assign irq       = |bank_stat;

endmodule

// File: rtl/gpio_edge_chk.sv
// Property checker for gpio_edge_ctrl, attached by bind below.
// Assumes NUM_PINS >= 32 so that the first bank is full.
module gpio_edge_chk
    import gpio_edge_pkg::*;
#(
    parameter int NUM_PINS = 71,
    parameter int ADDR_W   = 6
) (
    input logic                clk,
    input logic                rst_n,
    input logic                bus_wr,
    input logic                bus_rd,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic [BANK_W-1:0]   bus_wdata,
    input logic [BANK_W-1:0]   bus_rdata,
    input logic [NUM_PINS-1:0] pad_out,
    input logic [NUM_PINS-1:0] pad_oe,
    input logic                irq
);

    localparam logic [ADDR_W-1:0] A_SET0 = ADDR_W'(BASE_WORD + 2);
    localparam logic [ADDR_W-1:0] A_CLR0 = ADDR_W'(BASE_WORD + 3);
    localparam logic [ADDR_W-1:0] A_LOW  = ADDR_W'(BASE_WORD);

    AST_OE_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pad_oe == '0 && !irq)); // R1

    AST_IDLE_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |-> bus_rdata == '0); // R2

    AST_SET_FORCES_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_SET0) |=>
        ((pad_out[BANK_W-1:0] & $past(bus_wdata)) == $past(bus_wdata))); // R4

    AST_CLR_FORCES_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_CLR0) |=>
        ((pad_out[BANK_W-1:0] & $past(bus_wdata)) == '0)); // R4

    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !bus_wr) |=> irq); // R8

    AST_UNMAPPED_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr < A_LOW) |-> bus_rdata == '0); // R10

endmodule

bind gpio_edge_ctrl gpio_edge_chk #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe),
    .irq       (irq)
);

// File: tb/sim_gpio_edge_ctrl.sv
module sim_gpio_edge_ctrl;

    localparam int NP = 71;
    localparam int AW = 6;
    localparam int NB = 3;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          wr, rd;
    logic [AW-1:0] addr;
    logic [31:0]   wdata;
    logic [31:0]   rdata;
    logic [NP-1:0] pad_in, pad_out, pad_oe;
    logic          irq;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    logic [31:0] m_dir [NB];
    logic [31:0] m_out [NB];
    logic [31:0] m_rise[NB];
    logic [31:0] m_fall[NB];
    logic [31:0] m_stat[NB];

    always #2 clk = ~clk;

    gpio_edge_ctrl #(.NUM_PINS(NP), .ADDR_W(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(wr), .bus_rd(rd), .bus_addr(addr),
        .bus_wdata(wdata), .bus_rdata(rdata), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
    );

    function automatic logic [31:0] vmask(int b);
        if (b * 32 + 32 <= NP) return 32'hFFFF_FFFF;
        return (32'd1 << (NP - b * 32)) - 32'd1;
    endfunction

    function automatic logic [31:0] in_word(int b);
        logic [31:0] w = '0;
        for (int i = 0; i < 32; i++) if (b * 32 + i < NP) w[i] = pad_in[b * 32 + i];
        return w;
    endfunction

    function automatic bit mapped(int a);
        return a >= 4 && a < 4 + 10 * NB;
    endfunction

    function automatic logic [31:0] exp_read(int a);
        int b, k;
        if (!mapped(a)) return '0;
        b = (a - 4) / 10;
        k = (a - 4) % 10;
        case (k)
            0:       return m_dir[b];
            1, 2, 3: return m_out[b];
            4:       return in_word(b);
            5, 6:    return m_rise[b];
            7, 8:    return m_fall[b];
            default: return m_stat[b];
        endcase
    endfunction

    function automatic void model_write(int a, logic [31:0] d);
        int b, k;
        logic [31:0] m;
        if (!mapped(a)) return;
        b = (a - 4) / 10;
        k = (a - 4) % 10;
        m = vmask(b);
        case (k)
            0: m_dir[b]  = d & m;
            1: m_out[b]  = d & m;
            2: m_out[b]  = m_out[b] | (d & m);
            3: m_out[b]  = m_out[b] & ~d;
            5: m_rise[b] = m_rise[b] | (d & m);
            6: m_rise[b] = m_rise[b] & ~d;
            7: m_fall[b] = m_fall[b] | (d & m);
            8: m_fall[b] = m_fall[b] & ~d;
            9: m_stat[b] = m_stat[b] & ~d;
            default: ;
        endcase
    endfunction

    function automatic void model_pad(logic [NP-1:0] nv);
        for (int i = 0; i < NP; i++) begin
            if (!pad_in[i] && nv[i] && m_rise[i / 32][i % 32]) m_stat[i / 32][i % 32] = 1'b1;
            if (pad_in[i] && !nv[i] && m_fall[i / 32][i % 32]) m_stat[i / 32][i % 32] = 1'b1;
        end
    endfunction

    function automatic logic exp_irq();
        logic r = 1'b0;
        for (int b = 0; b < NB; b++) r = r | (|m_stat[b]);
        return r;
    endfunction

    task automatic check(string req, logic [127:0] act, logic [127:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(int a, logic [31:0] d);
        @(negedge clk);
        wr = 1'b1; addr = AW'(a); wdata = d;
        @(negedge clk);
        wr = 1'b0;
        model_write(a, d);
    endtask

    task automatic bus_read(int a, string req);
        @(negedge clk);
        rd = 1'b1; addr = AW'(a);
        #1;
        check(req, 128'(rdata), 128'(exp_read(a)));
        rd = 1'b0;
    endtask

    task automatic check_pads(string req);
        logic [NP-1:0] eo, ee;
        for (int i = 0; i < NP; i++) begin
            eo[i] = m_out[i / 32][i % 32];
            ee[i] = ~m_dir[i / 32][i % 32];
        end
        check(req, 128'(pad_out), 128'(eo));
        check(req, 128'(pad_oe), 128'(ee));
        check("R9 irq", 128'(irq), 128'(exp_irq()));
    endtask

    task automatic set_pads(logic [NP-1:0] nv);
        @(negedge clk);
        model_pad(nv);
        pad_in = nv;
        repeat (4) @(negedge clk);
    endtask

    task automatic toggle_pin(int p);
        logic [NP-1:0] nv;
        @(negedge clk);
        nv = pad_in;
        nv[p] = ~nv[p];
        model_pad(nv);
        pad_in = nv;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [NP-1:0] rp;
        void'($urandom(32'h5EED_0A11));
        rst_n = 1'b0; wr = 1'b0; rd = 1'b0; addr = '0; wdata = '0; pad_in = '0;
        for (int b = 0; b < NB; b++) begin
            m_dir[b] = vmask(b); m_out[b] = '0; m_rise[b] = '0; m_fall[b] = '0; m_stat[b] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check_pads("R1 reset pads");
        bus_read(4, "R1 dir bank0 all inputs");
        bus_read(24, "R1 R10 dir bank2 only valid bits");
        bus_read(13, "R1 status clear");

        // R2 pin mapping: pin 70 is bank 2 bit 6
        bus_write(26, 32'h0000_0040);
        check_pads("R2 pin 70 via bank2 set");
        check("R2 pad70", 128'(pad_out[70]), 128'(1'b1));
        @(negedge clk);
        check("R2 idle read zero", 128'(rdata), 128'(0));

        // R3 direction
        bus_write(14, 32'hFFFF_0000);
        check_pads("R3 bank1 direction to pads");
        bus_read(14, "R3 dir readback");

        // R4 output load, set, clear
        bus_write(5, 32'hA5A5_0F0F);
        bus_write(6, 32'h0000_F000);
        check_pads("R4 set data");
        bus_write(7, 32'h0000_0F01);
        check_pads("R4 clear data");
        bus_read(6, "R4 set word reads output");
        bus_read(7, "R4 clear word reads output");

        // R6 enables
        bus_write(9, 32'h0000_0200);
        bus_write(11, 32'h0000_0300);
        bus_write(12, 32'h0000_0100);
        bus_read(10, "R6 rise mask");
        bus_read(12, "R6 fall mask");

        // R5/R7 latency on pin 9 with rising enabled
        toggle_pin(9);
        @(negedge clk); rd = 1'b1; addr = 6'd8; #1;
        check("R5 input after 1 edge old", 128'(rdata[9]), 128'(1'b0));
        check("R7 no irq after 1 edge", 128'(irq), 128'(1'b0));
        rd = 1'b0;
        @(negedge clk); rd = 1'b1; addr = 6'd8; #1;
        check("R5 input after 2 edges new", 128'(rdata[9]), 128'(1'b1));
        check("R7 no irq after 2 edges", 128'(irq), 128'(1'b0));
        rd = 1'b0;
        @(negedge clk);
        check("R7 irq after 3 edges", 128'(irq), 128'(1'b1));
        bus_read(13, "R7 status bit 9");

        // R8 write-one-to-clear, and a zero write keeps the bit
        bus_write(13, 32'h0000_0000);
        bus_read(13, "R8 zero write keeps status");
        bus_write(13, 32'h0000_0200);
        check_pads("R8 clear drops irq");

        // R8 collision: clearing write on the cycle the edge is captured
        toggle_pin(9);
        repeat (4) @(negedge clk);
        toggle_pin(9);
        @(negedge clk);
        bus_write(13, 32'h0000_0200);
        m_stat[0][9] = 1'b1;
        bus_read(13, "R8 edge wins over clear");
        check("R8 irq held", 128'(irq), 128'(1'b1));
        bus_write(13, 32'h0000_0200);

        // R7 falling edge on pin 40 (bank 1 bit 8)
        bus_write(21, 32'h0000_0100);
        rp = pad_in; rp[40] = 1'b1; set_pads(rp);
        bus_read(23, "R7 rise not enabled on pin 40");
        rp[40] = 1'b0; set_pads(rp);
        bus_read(23, "R7 falling captured pin 40");
        check_pads("R9 irq from bank1");
        bus_write(23, 32'hFFFF_FFFF);

        // R9 last bank pin 66
        bus_write(29, 32'h0000_0004);
        rp[66] = 1'b1; set_pads(rp);
        bus_read(33, "R9 bank2 status");
        check_pads("R9 irq from bank2");
        bus_write(33, 32'h0000_0004);
        check_pads("R9 irq released");

        // R10 ignored writes
        bus_write(2, 32'hFFFF_FFFF);
        bus_write(36, 32'hFFFF_FFFF);
        bus_read(2, "R10 unmapped low");
        bus_read(36, "R10 unmapped high");
        bus_write(8, 32'hFFFF_FFFF);
        bus_read(8, "R10 input word write ignored");
        bus_write(24, 32'hFFFF_FFFF);
        bus_read(24, "R10 unused pins read zero");
        check_pads("R10 pads unchanged");

        // Random mix of writes, pad changes and reads
        for (int n = 0; n < 400; n++) begin
            if ($urandom_range(3, 0) == 0) begin
                rp = NP'({$urandom(), $urandom(), $urandom()});
                set_pads(rp);
                bus_read(13 + 10 * int'($urandom_range(2, 0)), "R7 random status");
            end else begin
                bus_write(int'($urandom_range(39, 0)), $urandom());
                check_pads("R3 R4 random pads");
            end
            bus_read(int'($urandom_range(39, 0)), "R2 R5 R6 random read");
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule